// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block collects up to 63 interrupt request lines and presents the processor with a single 3-bit pending level. Each source has a level from 1 to 7 and a rank within that level. When the processor acknowledges a level, the block picks the highest-ranked asserted source at that level. One cycle later it returns that source's vector number. It also records the level and priority it served in an 8-bit read-only status register.

Sources 1 to 7 have fixed settings. Source n sits at level n, at a mid-point rank that lies between the programmable priorities 3 and 4. Sources 8 to 63 get their level and priority from control registers that software writes over a small register bus. A level of 0 disables a source. Software must give every enabled source a unique level/priority pair.

Register map on `reg_addr`: address 0 is the status register, and addresses 1 to 63 are the control registers of the sources with the same numbers.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the status register reads 0x00, every writable control register reads 0x00 (disabled), and `irq_lvl` is 0.
- R2: A write to control register n (8 to 63) stores the level in bits 5–3 and the priority in bits 2–0. Bits 7–6 always read back as zero.
- R3: Control register n (1 to 7) reads {2'b00, level n, 3'b000}, and writes to it have no effect.
- R4: `irq_lvl` equals the highest level among asserted, enabled sources, or 0 when there are none. It changes one clock after `irq_req` changes.
- R5: A source whose control register holds level 0 never raises `irq_lvl` and never wins an acknowledge.
- R6: In the clock after `iack_stb`, `iack_vld` is high and `iack_vec` is 64 plus the number of the highest-priority asserted source at level `iack_lvl`.
- R7: The mid-point rank of a fixed source lies below programmable priorities 7–4 and above priorities 3–0 at the same level.
- R8: Each acknowledge loads the status register with {1'b0, acknowledged level, priority code}. The priority code is the source's priority 0–7, or 8 for a fixed source.
- R9: An acknowledge at a level with no asserted, enabled source returns vector 24 and loads the status register with {1'b0, level, 4'd0}.
- R10: Between acknowledges, the status register and `iack_vec` hold their values, and `iack_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 63 | Request lines; bit i is source i+1 |
| reg_addr | input | 6 | Register address: 0 is status, 1 to 63 are control |
| reg_wr | input | 1 | Write strobe for a control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_lvl | output | 3 | Highest pending level |
| iack_stb | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_vld | output | 1 | Vector valid, one cycle after the strobe |
| iack_vec | output | 8 | Returned vector number |

## Verification
The assertions assume that every enabled source has its own level/priority pair, since the winner is undefined for overlapping pairs. They also assume that `iack_stb` is a one-cycle pulse whose level is stable at the sampling edge. The bench programs distinct pairs only. It drives the request lines, the bus and the acknowledge on the falling clock edge. It leaves the requests unchanged from the cycle before a strobe until the vector is checked.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int RANK_W = 4;
  localparam int REG_W  = 8;

  // Rank 4 is the mid-point; programmable priorities 4..7 move up by one.
  function automatic logic [RANK_W-1:0] rank_of(input logic fixed,
                                                input logic [PRI_W-1:0] pri);
    logic [RANK_W-1:0] r;
    if (fixed)              r = RANK_W'(4);
    else if (pri >= PRI_W'(4)) r = RANK_W'(pri) + RANK_W'(1);
    else                    r = RANK_W'(pri);
    return r;
  endfunction
endpackage

// File: rtl/lvl_irq_cfg.sv
module lvl_irq_cfg
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wr_data,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic [NUM_SRC*PRI_W-1:0] pri_flat,
  output logic [REG_W-1:0]         rd_cfg
);
  logic unused_wdata;
  assign unused_wdata = ^wr_data[REG_W-1:LVL_W+PRI_W];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_FIXED) begin : g_fixed
      assign lvl_flat[i*LVL_W +: LVL_W] = LVL_W'(i + 1);
      assign pri_flat[i*PRI_W +: PRI_W] = '0;
    end else begin : g_prog
      logic [LVL_W-1:0] lvl_q, lvl_d;
      logic [PRI_W-1:0] pri_q, pri_d;
      logic             wr_hit;

      assign wr_hit = wr_en && (addr == ADDR_W'(i + 1));

      always_comb begin
        lvl_d = lvl_q;
        pri_d = pri_q;
        if (wr_hit) begin
          lvl_d = wr_data[PRI_W +: LVL_W];
          pri_d = wr_data[PRI_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q <= '0;
          pri_q <= '0;
        end else if (wr_hit) begin
          lvl_q <= lvl_d;
          pri_q <= pri_d;
        end
      end

      assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
      assign pri_flat[i*PRI_W +: PRI_W] = pri_q;
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr == ADDR_W'(i + 1)) begin
        rd_cfg = {2'b00, lvl_flat[i*LVL_W +: LVL_W], pri_flat[i*PRI_W +: PRI_W]};
      end
    end
  end
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic [NUM_SRC*PRI_W-1:0] pri_flat,
  input  logic [LVL_W-1:0]         ack_lvl,
  output logic [LVL_W-1:0]         pend_lvl,
  output logic                     win_hit,
  output logic [ADDR_W-1:0]        win_src,
  output logic [RANK_W-1:0]        win_code
);
  logic [NUM_SRC-1:0] req_q, req_d;
  logic [NUM_SRC-1:0] elig;
  logic [LVL_W-1:0]   src_lvl  [NUM_SRC];
  logic [RANK_W-1:0]  src_rank [NUM_SRC];
  logic [RANK_W-1:0]  src_code [NUM_SRC];

  assign req_d = irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
    localparam bit FIX = (i < NUM_FIXED);
    assign src_lvl[i]  = lvl_flat[i*LVL_W +: LVL_W];
    assign elig[i]     = req_q[i] && (src_lvl[i] != '0);
    assign src_rank[i] = rank_of(FIX, pri_flat[i*PRI_W +: PRI_W]);
    assign src_code[i] = FIX ? RANK_W'(8) : RANK_W'(pri_flat[i*PRI_W +: PRI_W]);
  end

  always_comb begin
    pend_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (src_lvl[i] > pend_lvl)) pend_lvl = src_lvl[i];
    end
  end

  always_comb begin
    logic [RANK_W-1:0] best;
    best     = '0;
    win_hit  = 1'b0;
    win_src  = '0;
    win_code = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (src_lvl[i] == ack_lvl) && (!win_hit || (src_rank[i] > best))) begin
        win_hit  = 1'b1;
        best     = src_rank[i];
        win_src  = ADDR_W'(i + 1);
        win_code = src_code[i];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int VEC_BASE  = 64,
  parameter int SPUR_VEC  = 24,
  localparam int ADDR_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [LVL_W-1:0]   irq_lvl,
  input  logic               iack_stb,
  input  logic [LVL_W-1:0]   iack_lvl,
  output logic               iack_vld,
  output logic [REG_W-1:0]   iack_vec
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic [NUM_SRC*PRI_W-1:0] pri_flat;
  logic [REG_W-1:0]         rd_cfg;
  logic                     win_hit;
  logic [ADDR_W-1:0]        win_src;
  logic [RANK_W-1:0]        win_code;

  lvl_irq_cfg #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W)) i_cfg (
    .clk(clk), .rst_n(rst_s), .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
    .lvl_flat(lvl_flat), .pri_flat(pri_flat), .rd_cfg(rd_cfg)
  );

  lvl_irq_arb #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W)) i_arb (
    .clk(clk), .rst_n(rst_s), .irq_req(irq_req), .lvl_flat(lvl_flat), .pri_flat(pri_flat),
    .ack_lvl(iack_lvl), .pend_lvl(irq_lvl), .win_hit(win_hit), .win_src(win_src),
    .win_code(win_code)
  );

  logic [REG_W-1:0] stat_q, stat_d;
  logic [REG_W-1:0] vec_q, vec_d;
  logic             vld_q, vld_d;

  always_comb begin
    vld_d  = iack_stb;
    vec_d  = vec_q;
    stat_d = stat_q;
    if (iack_stb) begin
      if (win_hit) begin
        vec_d  = REG_W'(VEC_BASE) + REG_W'(win_src);
        stat_d = {1'b0, iack_lvl, win_code};
      end else begin
        vec_d  = REG_W'(SPUR_VEC);
        stat_d = {1'b0, iack_lvl, 4'd0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      stat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (iack_stb) begin
        vec_q  <= vec_d;
        stat_q <= stat_d;
      end
    end
  end

  assign iack_vld  = vld_q;
  assign iack_vec  = vec_q;
  assign reg_rdata = (reg_addr == '0) ? stat_q : rd_cfg;
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int NUM_SRC  = 63,
  parameter int SPUR_VEC = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [2:0]         irq_lvl,
  input logic               iack_stb,
  input logic [2:0]         iack_lvl,
  input logic               iack_vld,
  input logic [7:0]         iack_vec,
  input logic [7:0]         stat
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|$past(irq_req)) |-> (irq_lvl == 3'd0));

  // R6
  vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_stb |=> iack_vld);

  // R10
  no_stray_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_stb |=> !iack_vld);

  // R8
  stat_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_vld |-> (stat[6:4] == $past(iack_lvl)));

  // R9
  spur_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_vld && (iack_vec == 8'(SPUR_VEC))) |-> (stat[3:0] == 4'd0));

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_stb |=> ($stable(stat) && $stable(iack_vec)));
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(.NUM_SRC(NUM_SRC), .SPUR_VEC(SPUR_VEC)) i_chk (
  .clk(clk), .rst_n(rst_s), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .iack_stb(iack_stb), .iack_lvl(iack_lvl), .iack_vld(iack_vld),
  .iack_vec(iack_vec), .stat(stat_q)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [62:0] irq_req;
  logic [5:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [2:0]  irq_lvl;
  logic        iack_stb;
  logic [2:0]  iack_lvl;
  logic        iack_vld;
  logic [7:0]  iack_vec;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lvl(irq_lvl),
    .iack_stb(iack_stb), .iack_lvl(iack_lvl), .iack_vld(iack_vld), .iack_vec(iack_vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    reg_addr = 6'(a);
    #0.5;
    d = int'(reg_rdata);
  endtask

  task automatic set_req(input int n, input logic v);
    irq_req[n-1] = v;
  endtask

  task automatic do_ack(input int lvl, input int exp_vec, input int exp_stat, input string tag);
    int d;
    @(negedge clk);
    iack_stb = 1'b1; iack_lvl = 3'(lvl);
    @(negedge clk);
    iack_stb = 1'b0;
    chk({tag, " vld"}, int'(iack_vld), 1);
    chk({tag, " vec"}, int'(iack_vec), exp_vec);
    rd_reg(0, d);
    chk({tag, " stat"}, d, exp_stat);
  endtask

  task automatic t_reset;
    int d;
    rd_reg(0, d);  chk("R1 status", d, 0);
    rd_reg(8, d);  chk("R1 reg8", d, 0);
    rd_reg(63, d); chk("R1 reg63", d, 0);
    chk("R1 irq_lvl", int'(irq_lvl), 0);
  endtask

  task automatic t_cfg;
    int d;
    wr_reg(10, 8'hFF); rd_reg(10, d); chk("R2 upper bits", d, 8'h3F);
    wr_reg(8, 8'h2B);  rd_reg(8, d);  chk("R2 reg8", d, 8'h2B);
    wr_reg(10, 8'h00);
  endtask

  task automatic t_fixed;
    int d;
    rd_reg(3, d); chk("R3 reg3", d, 8'h18);
    wr_reg(3, 8'h3F); rd_reg(3, d); chk("R3 write ignored", d, 8'h18);
    rd_reg(7, d); chk("R3 reg7", d, 8'h38);
  endtask

  task automatic t_pending;
    wr_reg(20, 8'h11);
    wr_reg(30, 8'h30);
    @(negedge clk);
    set_req(20, 1'b1);
    #0.5 chk("R4 not yet", int'(irq_lvl), 0);
    @(negedge clk);
    chk("R4 level 2", int'(irq_lvl), 2);
    set_req(30, 1'b1);
    @(negedge clk);
    chk("R4 level 6", int'(irq_lvl), 6);
    irq_req = '0;
    @(negedge clk);
    chk("R4 none", int'(irq_lvl), 0);
  endtask

  task automatic t_disabled;
    @(negedge clk);
    set_req(40, 1'b1);
    @(negedge clk);
    chk("R5 disabled level", int'(irq_lvl), 0);
    do_ack(0, 24, 8'h00, "R5 disabled ack");
    irq_req = '0;
  endtask

  task automatic t_ack_prog;
    wr_reg(31, 8'h35);
    wr_reg(32, 8'h32);
    set_req(30, 1'b1); set_req(31, 1'b1); set_req(32, 1'b1);
    do_ack(6, 95, 8'h65, "R6 R8 top pri5");
    set_req(31, 1'b0);
    do_ack(6, 96, 8'h62, "R6 R8 next pri2");
    irq_req = '0;
  endtask

  task automatic t_midpoint;
    wr_reg(9, 8'h2C);
    set_req(5, 1'b1); set_req(8, 1'b1); set_req(9, 1'b1);
    @(negedge clk);
    chk("R4 fixed level", int'(irq_lvl), 5);
    do_ack(5, 73, 8'h54, "R7 pri4 over mid");
    set_req(9, 1'b0);
    do_ack(5, 69, 8'h58, "R7 R8 mid over pri3");
    irq_req = '0;
  endtask

  task automatic t_spurious;
    set_req(30, 1'b1);
    do_ack(3, 24, 8'h30, "R9 spurious");
  endtask

  task automatic t_hold;
    int d;
    set_req(31, 1'b1); set_req(5, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 vld low", int'(iack_vld), 0);
    chk("R10 vec held", int'(iack_vec), 24);
    rd_reg(0, d); chk("R10 stat held", d, 8'h30);
    irq_req = '0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    iack_stb = 1'b0; iack_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_cfg;
    t_fixed;
    t_pending;
    t_disabled;
    t_ack_prog;
    t_midpoint;
    t_spurious;
    t_hold;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule